// File: doc/BRIEF.md
# Modular recurrence stream checker

This block watches a byte stream arriving in a fast local clock domain, one byte per cycle with a valid strobe. It checks that every byte is the successor of the byte before it under a fixed affine rule: the successor is the previous value plus a constant step, reduced modulo a constant that is not a power of two. The default rule is step 7 modulo 233. Any break in the rule latches an error output that is meant to drive a status LED directly.

After a synchronous reset the checker is unseeded. It takes the first in-range byte it receives as the start of the sequence and checks every later valid byte against the running prediction. Cycles with the strobe low do not move the checker, so a stream with gaps, such as one read from a dual-clock buffer that drains unevenly, raises no false alarms. A saturating mismatch counter can be enabled by parameter for use in the lab.

Top module: `rcs_stream_check`

## Requirements
- R1: While reset is high and on the cycle after it, err_led is 0 and mismatch_cnt is 0.
- R2: The first valid byte after reset whose value is below MODULUS (233) is taken as the seed and never flags an error.
- R3: Each later valid byte is expected to equal (previous + STEP) mod MODULUS, with defaults 7 and 233. A stream that follows the rule, including the wrap from 230 to 4, never raises err_led.
- R4: A valid byte that differs from the prediction sets err_led to 1. The change is visible after the clock edge that samples the byte.
- R5: err_led stays at 1 until the next reset, whatever data follows.
- R6: A valid byte of MODULUS (233) or above is always an error, even as the first byte after reset. It never becomes the seed. When the checker is already seeded, the prediction moves forward one step as though the expected byte had arrived.
- R7: Cycles with in_valid low leave err_led, mismatch_cnt and the prediction unchanged, whatever value in_byte has.
- R8: After an in-range mismatch, the checker takes the received byte as the new previous value, so that the byte following it is checked against that byte's successor.
- R9: With COUNT_EN = 1, mismatch_cnt rises by one for each byte that errs under R4 or R6, and it holds at its all-ones value (255 for CNT_W = 8) once it gets there.
- R10: A reset clears err_led and returns the checker to the unseeded state, so that the next in-range byte seeds again under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checking-domain clock |
| rst | input | 1 | Synchronous reset, active high: clears the error and the counter and re-arms seeding |
| in_valid | input | 1 | High when in_byte holds a stream byte |
| in_byte | input | DATA_W | Stream byte |
| err_led | output | 1 | Sticky error indicator |
| mismatch_cnt | output | CNT_W | Saturating count of erring bytes (held at 0 when COUNT_EN = 0) |

## Verification
Long sequences that follow the rule, started from several seeds and passing through the wrap at 233, show that the modular correction is right and that a correct stream stays quiet. The same stream with idle cycles carrying junk data shows that the strobe gates every state change. Single corrupted bytes, bytes out of range at the seed position and inside a run, and a byte sent right after a mismatch separate the resync behaviour from plain stepping of the prediction. A long burst of out-of-range bytes drives the counter to saturation, and a reset partway through the run shows the error clearing and the seed being captured again.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic {
      ST_UNSEEDED = 1'b0,
      ST_TRACKING = 1'b1
   } rcs_state_e;
endpackage

// File: rtl/rcs_predictor.sv
module rcs_predictor #(
   parameter int DATA_W  = 8,
   parameter int STEP    = 7,
   parameter int MODULUS = 233
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] prev,
   output logic [DATA_W-1:0] expected
);
   localparam int SUM_W = DATA_W + 1;
   localparam logic [SUM_W-1:0] STEP_W = STEP[SUM_W-1:0];
   localparam logic [SUM_W-1:0] MOD_W  = MODULUS[SUM_W-1:0];
   localparam bit MOD_IS_POW2 = (MODULUS == (1 << DATA_W));

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, prev} + STEP_W;

   generate
      if (MOD_IS_POW2) begin : g_wrap_free
         assign expected = sum[DATA_W-1:0];
      end else begin : g_wrap_fix
         logic [SUM_W-1:0] reduced;
         always_comb begin
            if (sum >= MOD_W) reduced = sum - MOD_W;
            else              reduced = sum;
         end
         assign expected = reduced[DATA_W-1:0];
      end
   endgenerate

   // R3: the prediction always lies inside the sequence range
   a_r3_pred_in_range: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, prev} < MOD_W) |-> ({1'b0, expected} < MOD_W));
endmodule

// File: rtl/rcs_tracker.sv
module rcs_tracker
   import rcs_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MODULUS = 233
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic [DATA_W-1:0] expected,
   output logic [DATA_W-1:0] prev,
   output logic              mismatch
);
   localparam logic [DATA_W:0] MOD_W = MODULUS[DATA_W:0];

   rcs_state_e state;
   logic       in_range;

   assign in_range = ({1'b0, in_byte} < MOD_W);

   always_comb begin
      mismatch = 1'b0;
      if (in_valid) begin
         if (!in_range)
            mismatch = 1'b1;
         else if (state == ST_TRACKING && in_byte != expected)
            mismatch = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_UNSEEDED;
         prev  <= '0;
      end else if (in_valid) begin
         unique case (state)
            ST_UNSEEDED: begin
               if (in_range) begin
                  state <= ST_TRACKING;
                  prev  <= in_byte;
               end
            end
            ST_TRACKING: begin
               prev <= in_range ? in_byte : expected;
            end
            default: state <= ST_UNSEEDED;
         endcase
      end
   end

   // R7: idle cycles do not move the prediction
   a_r7_prev_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(prev));
   // R2: the seed byte is never reported
   a_r2_seed_quiet: assert property (@(posedge clk) disable iff (rst)
      (state == ST_UNSEEDED && in_valid && in_range) |-> !mismatch);
endmodule

// File: rtl/rcs_flag_cnt.sv
module rcs_flag_cnt #(
   parameter int CNT_W    = 8,
   parameter bit COUNT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mismatch,
   output logic             err_led,
   output logic [CNT_W-1:0] mismatch_cnt
);
   always_ff @(posedge clk) begin
      if (rst)           err_led <= 1'b0;
      else if (mismatch) err_led <= 1'b1;
   end

   generate
      if (COUNT_EN) begin : g_counter
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)                    cnt_q <= '0;
            else if (mismatch && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
         end
         assign mismatch_cnt = cnt_q;

         // R9: the count never steps by more than one
         a_r9_cnt_step: assert property (@(posedge clk) disable iff (rst)
            (mismatch_cnt == $past(mismatch_cnt)) ||
            (mismatch_cnt == $past(mismatch_cnt) + 1'b1));
      end else begin : g_no_counter
         assign mismatch_cnt = '0;
      end
   endgenerate

   // R4: a mismatch shows on the LED after the edge
   a_r4_err_set: assert property (@(posedge clk) disable iff (rst)
      mismatch |=> err_led);
   // R5: the LED is sticky
   a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
      err_led |=> err_led);
   // R1: reset clears the outputs
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (!err_led && mismatch_cnt == '0));
endmodule

// File: rtl/rcs_stream_check.sv
module rcs_stream_check #(
   parameter int DATA_W   = 8,
   parameter int STEP     = 7,
   parameter int MODULUS  = 233,
   parameter int CNT_W    = 8,
   parameter bit COUNT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              err_led,
   output logic [CNT_W-1:0]  mismatch_cnt
);
   generate
      if (DATA_W < 1 || DATA_W > 30) begin : g_bad_width
         $error("rcs_stream_check: DATA_W out of range");
      end
      if (MODULUS < 2 || MODULUS > (1 << DATA_W)) begin : g_bad_mod
         $error("rcs_stream_check: MODULUS must fit in DATA_W bits");
      end
      if (STEP < 0 || STEP >= MODULUS) begin : g_bad_step
         $error("rcs_stream_check: STEP must be below MODULUS");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rcs_stream_check: CNT_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] prev;
   logic [DATA_W-1:0] expected;
   logic              mismatch;

   rcs_predictor #(
      .DATA_W  (DATA_W),
      .STEP    (STEP),
      .MODULUS (MODULUS)
   ) u_pred (
      .clk      (clk),
      .rst      (rst),
      .prev     (prev),
      .expected (expected)
   );

   rcs_tracker #(
      .DATA_W  (DATA_W),
      .MODULUS (MODULUS)
   ) u_track (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .expected (expected),
      .prev     (prev),
      .mismatch (mismatch)
   );

   rcs_flag_cnt #(
      .CNT_W    (CNT_W),
      .COUNT_EN (COUNT_EN)
   ) u_flag (
      .clk          (clk),
      .rst          (rst),
      .mismatch     (mismatch),
      .err_led      (err_led),
      .mismatch_cnt (mismatch_cnt)
   );

   // R7: idle cycles leave the outputs untouched
   a_r7_gap_stable: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(err_led) && $stable(mismatch_cnt)));
endmodule

// File: tb/rcs_stream_check_test.sv
module rcs_stream_check_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       err_led;
   logic [7:0] mismatch_cnt;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rcs_stream_check uut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .err_led      (err_led),
      .mismatch_cnt (mismatch_cnt)
   );

   function automatic logic [7:0] nxt(input logic [7:0] v);
      int s;
      s = int'(v) + 7;
      if (s >= 233) s = s - 233;
      return s[7:0];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input int e_err, input int e_cnt);
      check(err_led == e_err[0], {req, " err_led"}, int'(err_led), e_err);
      check(int'(mismatch_cnt) == e_cnt, {req, " mismatch_cnt"}, int'(mismatch_cnt), e_cnt);
   endtask

   // drive one byte at a falling edge; outputs settle by the next falling edge
   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hEE;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk_out("R1", 0, 0);
   endtask

   task automatic t_good_stream(input logic [7:0] seed);
      logic [7:0] v;
      do_reset();
      v = seed;
      send(v);
      chk_out("R2 seed", 0, 0);
      for (int i = 0; i < 150; i++) begin
         v = nxt(v);
         send(v);
      end
      chk_out("R3 long stream", 0, 0);
   endtask

   task automatic t_wrap();
      do_reset();
      send(8'd230);
      send(8'd4);
      chk_out("R3 wrap 230->4", 0, 0);
      send(8'd11);
      chk_out("R3 after wrap", 0, 0);
   endtask

   task automatic t_gap();
      logic [7:0] v;
      do_reset();
      v = 8'd50;
      send(v);
      for (int i = 0; i < 20; i++) begin
         v = nxt(v);
         send(v);
         @(negedge clk);
         in_byte = 8'd250;
         @(negedge clk);
         in_byte = 8'd3;
      end
      chk_out("R7 gaps with junk", 0, 0);
      v = nxt(v);
      send(v);
      chk_out("R7 prediction held over gaps", 0, 0);
   endtask

   task automatic t_mismatch();
      do_reset();
      send(8'd10);
      send(8'd17);
      chk_out("R3 ok", 0, 0);
      send(8'd50);
      chk_out("R4 mismatch", 1, 1);
      send(8'd57);
      chk_out("R8 resync", 1, 1);
      send(8'd64);
      send(8'd71);
      chk_out("R5 sticky", 1, 1);
      send(8'd0);
      chk_out("R9 second mismatch", 1, 2);
   endtask

   task automatic t_out_of_range();
      do_reset();
      send(8'd240);
      chk_out("R6 oor first byte", 1, 1);
      send(8'd3);
      chk_out("R6 seed after oor", 1, 1);
      send(8'd10);
      chk_out("R6 tracking", 1, 1);
      send(8'd233);
      chk_out("R6 oor in stream", 1, 2);
      send(8'd24);
      chk_out("R6 prediction advanced", 1, 2);
   endtask

   task automatic t_rearm();
      send(8'd99);
      do_reset();
      chk_out("R10 cleared", 0, 0);
      send(8'd100);
      chk_out("R10 reseed", 0, 0);
      send(8'd107);
      chk_out("R10 tracking", 0, 0);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 300; i++) send(8'd255);
      chk_out("R9 saturate", 1, 255);
   endtask

   initial begin
      t_reset();
      t_good_stream(8'd5);
      t_good_stream(8'd232);
      t_good_stream(8'd0);
      t_wrap();
      t_gap();
      t_mismatch();
      t_out_of_range();
      t_rearm();
      t_saturate();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule